// File: doc/BRIEF.md
# UART FIFO Ready-Pin Signaling

This block holds the transmit and receive byte queues of one UART channel. It drives the two active-low ready handshake pins that a host or a block-transfer engine watches, and the two transmitter status bits. The host writes transmit bytes and reads receive bytes. The serializer pulls transmit bytes and delivers receive bytes through its own pop and push ports.

Two control inputs, taken from bits 0 and 3 of the channel's FIFO control register, select one of three pin behaviours. With queues off, each direction acts as a single holding register. With queues on, the pins follow emptiness. In block-transfer mode the receive pin has hysteresis, governed by a trigger level and an external timeout strobe, and the transmit pin follows free space. Baud timing, framing and the timeout counter sit outside this block.

Top module: `uart_fifo_ready`

## Requirements
- R1: `fifo_en_i` (control bit 0) enables the queues and `blk_mode_i` (control bit 3) selects block-transfer mode. `blk_mode_i` has no effect while `fifo_en_i` is 0, and the block then runs in single-byte mode.
- R2: In single-byte mode each direction holds at most one byte. `rx_rdy_no` is low while a receive byte is held and high otherwise. `tx_rdy_no` is high while a transmit byte is held and low otherwise. A second host write while the byte is held is ignored.
- R3: In single-byte mode, a serializer receive push while a byte is unread replaces that byte and sets `rx_overrun_o`. A host read clears the flag.
- R4: With queues on and block mode off, `rx_rdy_no` is low exactly when the receive count is at least 1, and `tx_rdy_no` is low exactly when the transmit count is 0.
- R5: In block mode, `rx_rdy_no` goes low when the receive count reaches or passes `rx_trig_i` (1 to 127). It stays low while the count drains and goes high only when the count is 0.
- R6: In block mode, a one-cycle `rx_tmo_i` pulse with a non-empty receive queue drives `rx_rdy_no` low below the trigger level. The pin then holds low until the queue is empty.
- R7: In block mode, `tx_rdy_no` is low while the transmit queue has a free slot and high only at 128 bytes.
- R8: Each queue holds 128 bytes in arrival order. A host write to a full transmit queue is ignored and the count stays 128.
- R9: A host read of an empty receive queue leaves `host_rx_data_o` at the last byte read and the count at 0.
- R10: A pulse on `fifo_rst_i`, or a 1-to-0 change of `fifo_en_i`, empties both queues. After that clock edge `rx_rdy_no` is high and `tx_rdy_no` is low.
- R11: Both ready pins are registered. They take their new value after the same clock edge that changes the queue count.
- R12: `thr_empty_o` is high exactly when the transmit count is 0. `tx_idle_o` is high exactly when that holds and `ser_tx_busy_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Queue enable (control bit 0) |
| blk_mode_i | input | 1 | Block-transfer mode (control bit 3) |
| fifo_rst_i | input | 1 | Flush both queues |
| rx_trig_i | input | 7 | Receive trigger level |
| rx_tmo_i | input | 1 | Receive timeout strobe |
| host_tx_wr_i | input | 1 | Host transmit write |
| host_tx_data_i | input | 8 | Host transmit byte |
| host_rx_rd_i | input | 1 | Host receive read |
| host_rx_data_o | output | 8 | Last byte read by the host |
| ser_tx_rd_i | input | 1 | Serializer transmit pop |
| ser_tx_data_o | output | 8 | Oldest transmit byte |
| ser_tx_valid_o | output | 1 | Transmit queue not empty |
| ser_tx_busy_i | input | 1 | Transmit shift register busy |
| ser_rx_wr_i | input | 1 | Serializer receive push |
| ser_rx_data_i | input | 8 | Received byte |
| rx_rdy_no | output | 1 | Receive ready, active low |
| tx_rdy_no | output | 1 | Transmit ready, active low |
| thr_empty_o | output | 1 | Transmit holding area empty |
| tx_idle_o | output | 1 | Holding area and shifter empty |
| rx_overrun_o | output | 1 | Receive overrun flag |
| rx_level_o | output | 8 | Receive byte count |
| tx_level_o | output | 8 | Transmit byte count |

## Verification
The hardest states to reach are the two block-mode edges. One is the full transmit queue, where the pin flips and a further write must be dropped. The other is the receive hysteresis window, where the count sits between zero and the trigger level with the pin still low. The stimulus fills the transmit queue with 128 back-to-back writes and then adds a 129th. It then pops one byte to watch the pin release. For the receive side it pushes up to the trigger and drains byte by byte, checking the pin after every read. A timeout pulse below the trigger enters the same window by the other path.

// File: rtl/uart_fifo_ready_pkg.sv
package uart_fifo_ready_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FIFO   = 2'd1,
    MODE_BLOCK  = 2'd2
  } ufr_mode_e;

  function automatic ufr_mode_e decode_mode(input logic en, input logic blk);
    if (!en)     return MODE_SINGLE;
    else if (blk) return MODE_BLOCK;
    else          return MODE_FIFO;
  endfunction
endpackage

// File: rtl/ufr_fifo.sv
module ufr_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         single_i,
  input  logic                         ovw_en_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_next_o,
  output logic                         drop_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic full, do_pop, do_push, do_ovw;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = single_i ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && full && !do_pop;
  assign do_ovw  = drop_o && single_i && ovw_en_i;

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i) cnt_d = '0;
    else begin
      if (do_push) cnt_d = cnt_d + CW'(1);
      if (do_pop)  cnt_d = cnt_d - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push)     mem_q[wr_ptr_q] <= push_data_i;
    else if (do_ovw) mem_q[rd_ptr_q] <= push_data_i;
  end

  assign head_o     = mem_q[rd_ptr_q];
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0)); // R10
  AST_POP_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0 && !push_i && !flush_i) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/ufr_ready_gen.sv
module ufr_ready_gen
  import uart_fifo_ready_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  ufr_mode_e                   mode_i,
  input  logic [$clog2(DEPTH+1)-1:0]  rx_cnt_next_i,
  input  logic [$clog2(DEPTH+1)-1:0]  tx_cnt_next_i,
  input  logic [$clog2(DEPTH)-1:0]    rx_trig_i,
  input  logic                        rx_tmo_i,
  output logic                        rx_rdy_no,
  output logic                        tx_rdy_no
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] trig_eff;
  logic latch_q, latch_d, rx_n_d, tx_n_d;
  ufr_mode_e mode_q;

  assign trig_eff = (rx_trig_i == '0) ? CW'(1) : CW'(rx_trig_i);

  // receive hysteresis: set at trigger or timeout, clear only at empty
  always_comb begin
    if (rx_cnt_next_i == '0)                           latch_d = 1'b0;
    else if (rx_cnt_next_i >= trig_eff || rx_tmo_i)    latch_d = 1'b1;
    else                                               latch_d = latch_q;
  end

  always_comb begin
    if (mode_i == MODE_BLOCK) begin
      rx_n_d = !latch_d;
      tx_n_d = (tx_cnt_next_i == CW'(DEPTH));
    end else begin
      rx_n_d = (rx_cnt_next_i == '0);
      tx_n_d = (tx_cnt_next_i != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q   <= 1'b0;
      rx_rdy_no <= 1'b1;
      tx_rdy_no <= 1'b0;
      mode_q    <= MODE_SINGLE;
    end else begin
      latch_q   <= latch_d;
      rx_rdy_no <= rx_n_d;
      tx_rdy_no <= tx_n_d;
      mode_q    <= mode_i;
    end
  end

  AST_BLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BLOCK && mode_i == MODE_BLOCK && !rx_rdy_no && rx_cnt_next_i != '0)
      |=> !rx_rdy_no); // R5
endmodule

// File: rtl/uart_fifo_ready.sv
module uart_fifo_ready
  import uart_fifo_ready_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fifo_en_i,
  input  logic                        blk_mode_i,
  input  logic                        fifo_rst_i,
  input  logic [$clog2(DEPTH)-1:0]    rx_trig_i,
  input  logic                        rx_tmo_i,
  input  logic                        host_tx_wr_i,
  input  logic [DW-1:0]               host_tx_data_i,
  input  logic                        host_rx_rd_i,
  output logic [DW-1:0]               host_rx_data_o,
  input  logic                        ser_tx_rd_i,
  output logic [DW-1:0]               ser_tx_data_o,
  output logic                        ser_tx_valid_o,
  input  logic                        ser_tx_busy_i,
  input  logic                        ser_rx_wr_i,
  input  logic [DW-1:0]               ser_rx_data_i,
  output logic                        rx_rdy_no,
  output logic                        tx_rdy_no,
  output logic                        thr_empty_o,
  output logic                        tx_idle_o,
  output logic                        rx_overrun_o,
  output logic [$clog2(DEPTH+1)-1:0]  rx_level_o,
  output logic [$clog2(DEPTH+1)-1:0]  tx_level_o
);
  localparam int CW = $clog2(DEPTH+1);

  ufr_mode_e     mode;
  logic          en_q, flush, single;
  logic [CW-1:0] rx_cnt, rx_cnt_d, tx_cnt, tx_cnt_d;
  logic [DW-1:0] rx_head, rx_data_q;
  logic          rx_drop, tx_drop, ovr_q;

  assign mode   = decode_mode(fifo_en_i, blk_mode_i);
  assign single = (mode == MODE_SINGLE);
  assign flush  = fifo_rst_i || (en_q && !fifo_en_i);

  ufr_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .single_i    (single),
    .ovw_en_i    (1'b1),
    .push_i      (ser_rx_wr_i),
    .push_data_i (ser_rx_data_i),
    .pop_i       (host_rx_rd_i),
    .head_o      (rx_head),
    .cnt_o       (rx_cnt),
    .cnt_next_o  (rx_cnt_d),
    .drop_o      (rx_drop)
  );

  ufr_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .single_i    (single),
    .ovw_en_i    (1'b0),
    .push_i      (host_tx_wr_i),
    .push_data_i (host_tx_data_i),
    .pop_i       (ser_tx_rd_i),
    .head_o      (ser_tx_data_o),
    .cnt_o       (tx_cnt),
    .cnt_next_o  (tx_cnt_d),
    .drop_o      (tx_drop)
  );

  ufr_ready_gen #(.DEPTH(DEPTH)) u_ready (
    .clk_i, .rst_ni,
    .mode_i        (mode),
    .rx_cnt_next_i (rx_cnt_d),
    .tx_cnt_next_i (tx_cnt_d),
    .rx_trig_i     (rx_trig_i),
    .rx_tmo_i      (rx_tmo_i),
    .rx_rdy_no     (rx_rdy_no),
    .tx_rdy_no     (tx_rdy_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rx_data_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      en_q <= fifo_en_i;
      if (host_rx_rd_i && rx_cnt != '0) rx_data_q <= rx_head;
      if (flush)             ovr_q <= 1'b0;
      else if (rx_drop)      ovr_q <= 1'b1;
      else if (host_rx_rd_i) ovr_q <= 1'b0;
    end
  end

  assign host_rx_data_o = rx_data_q;
  assign ser_tx_valid_o = (tx_cnt != '0);
  assign thr_empty_o    = (tx_cnt == '0);
  assign tx_idle_o      = thr_empty_o && !ser_tx_busy_i;
  assign rx_overrun_o   = ovr_q;
  assign rx_level_o     = rx_cnt;
  assign tx_level_o     = tx_cnt;

  AST_RX_EMPTY_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == '0) |-> rx_rdy_no); // R5
  AST_TX_RST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !tx_rdy_no); // R10
  AST_TX_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_drop && !flush) |=> $stable(tx_cnt)); // R8
endmodule

// File: tb/uart_fifo_ready_tb.sv
`timescale 1ns/1ps
module uart_fifo_ready_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic fifo_en = 0, blk = 0, frst = 0, tmo = 0;
  logic [6:0] trig = 7'd1;
  logic tx_wr = 0, rx_rd = 0, s_rd = 0, s_busy = 0, s_wr = 0;
  logic [7:0] tx_d = 0, s_d = 0;
  logic [7:0] rx_q, s_q, rx_lvl, tx_lvl;
  logic s_v, rx_n, tx_n, thr_e, idle, ovr;

  int checks = 0, fails = 0;

  uart_fifo_ready u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .blk_mode_i(blk),
    .fifo_rst_i(frst), .rx_trig_i(trig), .rx_tmo_i(tmo),
    .host_tx_wr_i(tx_wr), .host_tx_data_i(tx_d), .host_rx_rd_i(rx_rd),
    .host_rx_data_o(rx_q), .ser_tx_rd_i(s_rd), .ser_tx_data_o(s_q),
    .ser_tx_valid_o(s_v), .ser_tx_busy_i(s_busy), .ser_rx_wr_i(s_wr),
    .ser_rx_data_i(s_d), .rx_rdy_no(rx_n), .tx_rdy_no(tx_n),
    .thr_empty_o(thr_e), .tx_idle_o(idle), .rx_overrun_o(ovr),
    .rx_level_o(rx_lvl), .tx_level_o(tx_lvl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] d);
    s_wr = 1; s_d = d; @(negedge clk); s_wr = 0;
  endtask
  task automatic tx_push(input logic [7:0] d);
    tx_wr = 1; tx_d = d; @(negedge clk); tx_wr = 0;
  endtask
  task automatic rx_pop();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic tx_pop();
    s_rd = 1; @(negedge clk); s_rd = 0;
  endtask
  task automatic set_mode(input logic en, input logic b);
    fifo_en = en; blk = b; @(negedge clk);
  endtask
  task automatic do_flush();
    frst = 1; @(negedge clk); frst = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset rx_rdy", rx_n, 1);
    chk("R10 reset tx_rdy", tx_n, 0);
    chk("R12 reset thr_empty", thr_e, 1);
    chk("R12 reset idle", idle, 1);
  endtask

  task automatic t_single();
    set_mode(0, 1); // R1: block bit ignored with queues off
    rx_push(8'h11);
    chk("R1 single rx_rdy low", rx_n, 0);
    chk("R2 rx count", rx_lvl, 1);
    tx_push(8'hA1);
    chk("R2 tx_rdy high", tx_n, 1);
    tx_push(8'hA2);
    chk("R2 tx second write ignored", tx_lvl, 1);
    chk("R2 tx data kept", s_q, 8'hA1);
    rx_push(8'h22);
    chk("R3 overrun set", ovr, 1);
    chk("R3 count stays 1", rx_lvl, 1);
    rx_pop();
    chk("R3 overwritten byte", rx_q, 8'h22);
    chk("R3 overrun cleared", ovr, 0);
    chk("R2 rx_rdy high when empty", rx_n, 1);
    rx_pop();
    chk("R9 pop empty data", rx_q, 8'h22);
    chk("R9 pop empty count", rx_lvl, 0);
    tx_pop();
    chk("R2 tx_rdy low when empty", tx_n, 0);
  endtask

  task automatic t_fifo_mode();
    set_mode(1, 0);
    tx_push(8'h01);
    chk("R4 tx_rdy high 1 byte", tx_n, 1);
    tx_push(8'h02);
    tx_pop();
    chk("R4 tx_rdy high 1 left", tx_n, 1);
    tx_pop();
    chk("R4 tx_rdy low empty", tx_n, 0);
    rx_push(8'h31);
    chk("R4 rx_rdy low 1 byte", rx_n, 0);
    rx_push(8'h32);
    rx_pop();
    chk("R8 order first", rx_q, 8'h31);
    rx_pop();
    chk("R8 order second", rx_q, 8'h32);
    chk("R4 rx_rdy high empty", rx_n, 1);
  endtask

  task automatic t_block_rx();
    set_mode(1, 1);
    trig = 7'd4;
    for (int i = 0; i < 3; i++) rx_push(8'(8'h40 + i));
    chk("R5 below trigger high", rx_n, 1);
    rx_push(8'h43);
    chk("R11 low after trigger edge", rx_n, 0);
    for (int i = 0; i < 3; i++) begin
      rx_pop();
      chk("R5 holds low while draining", rx_n, 0);
    end
    rx_pop();
    chk("R5 high at empty", rx_n, 1);
    chk("R8 last byte", rx_q, 8'h43);
  endtask

  task automatic t_timeout();
    trig = 7'd10;
    rx_push(8'h50);
    rx_push(8'h51);
    chk("R6 no timeout high", rx_n, 1);
    tmo = 1; @(negedge clk); tmo = 0;
    chk("R6 timeout low", rx_n, 0);
    @(negedge clk);
    chk("R6 holds after timeout", rx_n, 0);
    rx_pop();
    chk("R6 still low 1 byte", rx_n, 0);
    rx_pop();
    chk("R6 high at empty", rx_n, 1);
  endtask

  task automatic t_block_tx();
    for (int i = 0; i < 127; i++) tx_push(8'(i));
    chk("R7 low with free slot", tx_n, 0);
    tx_push(8'd127);
    chk("R7 high at full", tx_n, 1);
    chk("R8 count 128", tx_lvl, 128);
    tx_push(8'hEE);
    chk("R8 write to full ignored", tx_lvl, 128);
    chk("R8 oldest first", s_q, 0);
    tx_pop();
    chk("R7 low after pop", tx_n, 0);
    chk("R8 next byte", s_q, 1);
  endtask

  task automatic t_flush();
    rx_push(8'h61);
    rx_push(8'h62);
    tx_wr = 1; tx_d = 8'h70; frst = 1; @(negedge clk); tx_wr = 0; frst = 0;
    chk("R10 rst tx empty", tx_lvl, 0);
    chk("R10 rst rx empty", rx_lvl, 0);
    chk("R10 rst tx_rdy low", tx_n, 0);
    chk("R10 rst rx_rdy high", rx_n, 1);
    set_mode(1, 0);
    rx_push(8'h63);
    tx_push(8'h71);
    tx_push(8'h72);
    set_mode(0, 0);
    chk("R10 disable rx empty", rx_lvl, 0);
    chk("R10 disable tx empty", tx_lvl, 0);
    chk("R10 disable rx_rdy high", rx_n, 1);
    chk("R10 disable tx_rdy low", tx_n, 0);
  endtask

  task automatic t_status();
    set_mode(1, 0);
    s_busy = 1; @(negedge clk);
    chk("R12 idle low while busy", idle, 0);
    chk("R12 thr empty", thr_e, 1);
    tx_push(8'h81);
    chk("R12 thr not empty", thr_e, 0);
    tx_pop();
    s_busy = 0; @(negedge clk);
    chk("R12 idle", idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_fifo_mode();
    t_block_rx();
    t_timeout();
    t_block_tx();
    do_flush();
    t_flush();
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule